// File: doc/BRIEF.md
# One-Bit Input Digital Phase-Locked Loop

This block is a compact all-digital phase-locked loop that follows a one-bit square-wave input, such as a hard-limited audio tone from a frequency-shift-keyed link. It does one update for each pulse of a one-cycle sample strobe. Between strobes its state holds, so it can run from a fast system clock at an audio-rate sample cadence.

The loop has three stages. An exclusive-OR phase detector compares the input bit with the oscillator bit. It outputs either nothing or a programmable gain step, and all the loop gain sits in that step. A first-order recursive low-pass filter smooths the detector output. Its fractional coefficient is an integer over a power-of-two divisor, and the division is an arithmetic shift. A numerically controlled oscillator then adds a base tuning word plus the filter value to its phase accumulator on each sample. The oscillator frequency therefore runs from the base word up to the base word plus the gain.

The filter value is the demodulated frequency error. A downstream slicer decides symbols from it. A bipolar detector mode is also provided: it centres the detector output on zero, for loop filters that integrate.

Top module: `sqpll_core`

## Requirements
- R1: While reset is asserted, `phase_out` and `lp_out` are zero and `sq_out` is 0. Reset is asynchronous active-low and is released synchronously after two clock edges.
- R2: When `sample_en` is low, `phase_out` and `lp_out` keep their values, whatever `din`, `tune_word`, `gain`, `coef` or `pd_bipolar` do.
- R3: On each sample, `phase_out` becomes (previous `phase_out` + `tune_word` + previous `lp_out` sign-extended) modulo 2^16. Wraparound is normal operation.
- R4: `sq_out` equals bit 15 (the most significant bit) of `phase_out`.
- R5: With `pd_bipolar`=0, the detector value is 0 when `din` equals `sq_out` and `gain` when they differ.
- R6: With `pd_bipolar`=1, the detector value is -(`gain`>>1) when `din` equals `sq_out` and +(`gain`>>1) when they differ.
- R7: On each sample, `lp_out` becomes `lp_out` + floor(c*(pd - `lp_out`)/128), with a floor division (arithmetic shift right by 7), where pd is the detector value and c the effective coefficient.
- R8: The effective coefficient c is `coef` when `coef` <= 128, and 128 for any larger `coef`.
- R9: With `pd_bipolar`=0 and `lp_out` starting within 0..`gain`, every sample leaves `lp_out` within 0..`gain`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-cycle sample strobe; all state advances only on it |
| din | input | 1 | Hard-limited input bit |
| pd_bipolar | input | 1 | 0: detector gives 0/gain; 1: detector gives -gain/2 or +gain/2 |
| tune_word | input | 16 | Base phase increment, f_low*65536/f_sample |
| gain | input | 12 | Detector gain step (unsigned) |
| coef | input | 8 | Filter coefficient numerator over 128 |
| sq_out | output | 1 | Recovered square wave (oscillator bit) |
| lp_out | output | 13 | Loop filter value, two's complement |
| phase_out | output | 16 | Oscillator phase accumulator |

## Verification
Some behaviours are checked by assertions on every cycle. State freezes between strobes. Each sample moves the accumulator by the base word plus the filter value. The filter value moves toward the detector level and never past it. In unipolar mode the filter value stays inside 0..gain.

Other behaviours only the bench scenarios can show. These cover the exact detector levels in both modes, the floor rounding of the shift, the clipping of large coefficients, and wrap of the accumulator at a high tuning word. They also cover the lock behaviour against a tone generated in the bench, and the reset values.

// File: rtl/sqpll_pkg.sv
package sqpll_pkg;

  // Detector output convention.
  typedef enum logic {
    PD_UNIPOLAR = 1'b0,   // 0 or full gain
    PD_BIPOLAR  = 1'b1    // -gain/2 or +gain/2
  } pd_mode_e;

endpackage

// File: rtl/sqpll_phase_det.sv
module sqpll_phase_det
  import sqpll_pkg::*;
#(
  parameter int GAIN_W = 12,
  parameter int LP_W   = GAIN_W + 1
) (
  input  logic                     din,
  input  logic                     osc_bit,
  input  pd_mode_e                 mode,
  input  logic [GAIN_W-1:0]        gain,
  output logic signed [LP_W-1:0]   pd
);

  logic                   mismatch;
  logic [LP_W-1:0]        full_step;
  logic [LP_W-1:0]        half_step;

  always_comb begin
    mismatch  = din ^ osc_bit;
    full_step = LP_W'(gain);
    half_step = LP_W'(gain >> 1);
    case (mode)
      PD_BIPOLAR:  pd = mismatch ? $signed(half_step) : -$signed(half_step);
      default:     pd = mismatch ? $signed(full_step) : '0;
    endcase
  end

endmodule

// File: rtl/sqpll_loop_filter.sv
module sqpll_loop_filter #(
  parameter int LP_W   = 13,
  parameter int COEF_W = 8,
  parameter int SHIFT  = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [LP_W-1:0]   pd,
  input  logic [COEF_W-1:0]        coef,
  output logic signed [LP_W-1:0]   lp
);

  localparam int DIFF_W = LP_W + 1;
  localparam int CE_W   = SHIFT + 1;
  localparam int MUL_W  = DIFF_W + CE_W + 1;
  localparam logic [COEF_W-1:0] COEF_MAX = COEF_W'(2 ** SHIFT);

  logic signed [LP_W-1:0]   lp_q;
  logic signed [LP_W-1:0]   lp_d;
  logic [CE_W-1:0]          coef_eff;
  logic signed [DIFF_W-1:0] diff;
  logic [MUL_W-1:0]         diff_x;
  logic [MUL_W-1:0]         coef_x;
  logic signed [MUL_W-1:0]  prod;
  logic signed [MUL_W-1:0]  step;

  // Next-state: LP + (c*(PD-LP)) >>> SHIFT, with c clipped to 2^SHIFT
  always_comb begin
    coef_eff = (coef > COEF_MAX) ? CE_W'(2 ** SHIFT) : coef[CE_W-1:0];
    diff     = $signed({pd[LP_W-1], pd}) - $signed({lp_q[LP_W-1], lp_q});
    diff_x   = {{(MUL_W-DIFF_W){diff[DIFF_W-1]}}, diff};
    coef_x   = {{(MUL_W-CE_W){1'b0}}, coef_eff};
    prod     = $signed(diff_x) * $signed(coef_x);
    step     = prod >>> SHIFT;
    lp_d     = lp_q + step[LP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lp_q <= '0;
    else if (en)  lp_q <= lp_d;
  end

  assign lp = lp_q;

  // R2: no movement between strobes
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(lp_q));

  // R7: each update moves toward the detector level and never passes it
  p_toward_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (($past(pd) >= $past(lp_q)) ?
             (lp_q >= $past(lp_q) && lp_q <= $past(pd)) :
             (lp_q <= $past(lp_q) && lp_q >= $past(pd))));

endmodule

// File: rtl/sqpll_nco.sv
module sqpll_nco #(
  parameter int ACC_W = 16,
  parameter int LP_W  = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [ACC_W-1:0]         tune,
  input  logic signed [LP_W-1:0]   lp,
  output logic [ACC_W-1:0]         acc,
  output logic                     osc_bit
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] lp_ext;

  // Bring the signed filter value to accumulator width
  generate
    if (LP_W < ACC_W) begin : g_sext
      assign lp_ext = {{(ACC_W-LP_W){lp[LP_W-1]}}, lp};
    end else begin : g_trunc
      assign lp_ext = lp[ACC_W-1:0];
    end
  endgenerate

  // Modulo-2^ACC_W advance; wrap is intended
  always_comb begin
    acc_d = acc_q + tune + lp_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (en)  acc_q <= acc_d;
  end

  assign acc     = acc_q;
  assign osc_bit = acc_q[ACC_W-1];

  // R2: phase frozen between strobes
  p_hold_acc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));

  // R3: phase step equals base word plus filter value seen at the strobe
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (ACC_W'(acc_q - $past(acc_q)) == ACC_W'($past(tune) + $past(lp_ext))));

endmodule

// File: rtl/sqpll_core.sv
module sqpll_core
  import sqpll_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int GAIN_W = 12,
  parameter int COEF_W = 8,
  parameter int SHIFT  = 7,
  localparam int LP_W  = GAIN_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_en,
  input  logic                    din,
  input  logic                    pd_bipolar,
  input  logic [ACC_W-1:0]        tune_word,
  input  logic [GAIN_W-1:0]       gain,
  input  logic [COEF_W-1:0]       coef,
  output logic                    sq_out,
  output logic signed [LP_W-1:0]  lp_out,
  output logic [ACC_W-1:0]        phase_out
);

  // Asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  pd_mode_e                pd_mode;
  logic                    osc_bit;
  logic signed [LP_W-1:0]  pd_val;
  logic signed [LP_W-1:0]  lp_val;
  logic [ACC_W-1:0]        acc_val;

  assign pd_mode = pd_mode_e'(pd_bipolar);

  sqpll_phase_det #(
    .GAIN_W (GAIN_W),
    .LP_W   (LP_W)
  ) u_pd (
    .din     (din),
    .osc_bit (osc_bit),
    .mode    (pd_mode),
    .gain    (gain),
    .pd      (pd_val)
  );

  sqpll_loop_filter #(
    .LP_W   (LP_W),
    .COEF_W (COEF_W),
    .SHIFT  (SHIFT)
  ) u_lf (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (sample_en),
    .pd    (pd_val),
    .coef  (coef),
    .lp    (lp_val)
  );

  sqpll_nco #(
    .ACC_W (ACC_W),
    .LP_W  (LP_W)
  ) u_nco (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en      (sample_en),
    .tune    (tune_word),
    .lp      (lp_val),
    .acc     (acc_val),
    .osc_bit (osc_bit)
  );

  assign sq_out    = osc_bit;
  assign lp_out    = lp_val;
  assign phase_out = acc_val;

  // R9: unipolar mode keeps the filter value inside 0..gain
  p_range_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sample_en && !pd_bipolar && lp_val >= 0 &&
     lp_val <= $signed({1'b0, gain}))
    |=> (lp_val >= 0 && lp_val <= $signed({1'b0, $past(gain)})));

  // R5: in unipolar mode a matching bit never raises the filter value
  p_match_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sample_en && !pd_bipolar && (din == sq_out) && lp_val >= 0)
    |=> (lp_val <= $past(lp_val)));

endmodule

// File: tb/sqpll_core_tb.sv
module sqpll_core_tb;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               sample_en;
  logic               din;
  logic               pd_bipolar;
  logic [15:0]        tune_word;
  logic [11:0]        gain;
  logic [7:0]         coef;
  logic               sq_out;
  logic signed [12:0] lp_out;
  logic [15:0]        phase_out;

  int n_chk  = 0;
  int n_fail = 0;
  int m_acc  = 0;
  int m_lp   = 0;
  int s_acc  = 0;

  always #4 clk = ~clk;   // 125 MHz

  sqpll_core u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_en  (sample_en),
    .din        (din),
    .pd_bipolar (pd_bipolar),
    .tune_word  (tune_word),
    .gain       (gain),
    .coef       (coef),
    .sq_out     (sq_out),
    .lp_out     (lp_out),
    .phase_out  (phase_out)
  );

  function automatic int pd_f(bit d, bit osc, int g, bit bip);
    if (bip) return (d == osc) ? -(g >> 1) : (g >> 1);
    return (d == osc) ? 0 : g;
  endfunction

  function automatic int lp_f(int lp, int pd, int c);
    int cc = (c > 128) ? 128 : c;
    return lp + ((cc * (pd - lp)) >>> 7);
  endfunction

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Drive one cycle, advance model, compare at the next falling edge
  task automatic cyc(bit en, bit d, string req);
    int p;
    int na;
    int nl;
    sample_en = en;
    din       = d;
    if (en) begin
      p  = pd_f(d, m_acc[15], int'(gain), pd_bipolar);
      na = (m_acc + int'(tune_word) + m_lp) & 32'hFFFF;
      nl = lp_f(m_lp, p, int'(coef));
      m_acc = na;
      m_lp  = nl;
    end
    @(negedge clk);
    chk({req, " R3 phase"}, int'(phase_out), m_acc);
    chk({req, " R7 filter"}, int'(lp_out), m_lp);
    chk({req, " R4 msb"}, int'(sq_out), (m_acc >> 15) & 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sample_en = 1'b0;
    @(negedge clk);
    chk("R1 phase reset", int'(phase_out), 0);
    chk("R1 filter reset", int'(lp_out), 0);
    chk("R1 msb reset", int'(sq_out), 0);
    m_acc = 0;
    m_lp  = 0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    din = 1'b0; pd_bipolar = 1'b0;
    tune_word = 16'd0; gain = 12'd0; coef = 8'd0;
    @(negedge clk);
    do_reset();

    // R5 directed: lp=0, osc bit 0
    gain = 12'd800; coef = 8'd128; tune_word = 16'd0;
    cyc(1'b1, 1'b0, "R5 match");
    chk("R5 match gives zero", int'(lp_out), 0);
    cyc(1'b1, 1'b1, "R5 differ");
    chk("R5 differ gives gain", int'(lp_out), 800);

    // R2: idle strobe with every input wiggling
    for (int i = 0; i < 20; i++) begin
      tune_word = 16'($urandom); gain = 12'($urandom);
      coef = 8'($urandom); pd_bipolar = 1'($urandom);
      cyc(1'b0, 1'($urandom), "R2 hold");
    end
    chk("R2 filter held", int'(lp_out), 800);

    // R8: oversize coefficient acts as 128
    do_reset();
    pd_bipolar = 1'b0; gain = 12'd1000; coef = 8'd255; tune_word = 16'd0;
    cyc(1'b1, 1'b1, "R8 clip");
    chk("R8 clip reaches pd", int'(lp_out), 1000);
    coef = 8'd3;
    cyc(1'b1, 1'b0, "R7 floor");
    chk("R7 floor step", int'(lp_out), 1000 + ((3 * (0 - 1000)) >>> 7));

    // R6: bipolar levels
    do_reset();
    pd_bipolar = 1'b1; gain = 12'd601; coef = 8'd128; tune_word = 16'd0;
    cyc(1'b1, 1'b0, "R6 match");
    chk("R6 match level", int'(lp_out), -300);
    cyc(1'b1, 1'b1, "R6 differ");
    chk("R6 differ level", int'(lp_out), 300);

    // R3: wrap at a high tuning word
    do_reset();
    pd_bipolar = 1'b0; gain = 12'd0; coef = 8'd0; tune_word = 16'hFFF0;
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, "R3 wrap");

    // Tracking a bench tone, unipolar, with R9 bound check
    do_reset();
    pd_bipolar = 1'b0; tune_word = 16'd4750; gain = 12'd2200; coef = 8'd24;
    s_acc = 0;
    for (int i = 0; i < 3000; i++) begin
      s_acc = (s_acc + 5843) & 32'hFFFF;
      cyc(1'b1, s_acc[15], "R5 track");
      chk("R9 range", int'(lp_out >= 0 && lp_out <= 2200), 1);
    end

    // Bipolar tracking
    pd_bipolar = 1'b1; coef = 8'd40;
    for (int i = 0; i < 2000; i++) begin
      s_acc = (s_acc + 5500) & 32'hFFFF;
      cyc(1'b1, s_acc[15], "R6 track");
    end

    // Random mix of everything
    for (int seg = 0; seg < 40; seg++) begin
      pd_bipolar = 1'($urandom);
      tune_word  = 16'($urandom);
      gain       = 12'($urandom);
      coef       = 8'($urandom);
      for (int i = 0; i < 200; i++)
        cyc(1'($urandom_range(0, 2) != 0), 1'($urandom), "R7 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule